// File: doc/BRIEF.md
# Fault Capture and Drive Shutdown Unit

This unit sits between an external fault input pin and a three-phase PWM motor drive stage. While the unit is disabled, it passes the synchronised pin level straight through to the CPU's non-maskable interrupt line and leaves the drive outputs and flags alone. While it is enabled, the unit takes over the pin. It recognises a fault when the synchronised pin matches a programmable active level. On a fault it latches a sticky pending flag, releases every dedicated drive output to high impedance by clearing the master output-enable bit, and raises an active-high request towards an edge-sensitive top-level interrupt controller.

Software sees the unit as two small registers behind a single-cycle write strobe, plus a combinational read vector. Software can clear the pending flag only once the fault pin has returned to its idle level, so a fault that is still present cannot be dismissed and lost. The request stays high for as long as the flag is set. A second fault therefore produces no new edge until the flag has been cleared. The drive stage stays released until software enables it again, and it cannot be enabled while the flag is still set.

The control flow is a four-state machine. BYPASS means the unit is disabled. ARMED means it is enabled and watching the pin. TRIPPED means the flag is set and the fault is still active. HELD means the flag is set and the fault is gone. The transitions are named ENABLE (BYPASS to ARMED), DISARM (ARMED to BYPASS), TRIP (ARMED to TRIPPED), RELEASE (TRIPPED to HELD), RETRIP (HELD to TRIPPED) and ACK (TRIPPED or HELD to ARMED, or to BYPASS when the unit is disabled).

Top module: `fault_guard`

## Requirements
- R1: After reset the read vector `rd_vec` = {enable, polarity, output enable, pending} reads 4'b0100, meaning disabled, active-high polarity, drive released and nothing pending. `irq_req` is 0 and every bit of `pwm_drv_en` is 0.
- R2: While enable is 0, `nmi_cpu` equals the fault pin as it was two clock edges earlier (two-flop synchroniser). The pin never sets pending, never changes output enable and never raises `irq_req`.
- R3: While enable is 1, `nmi_cpu` is held at 0. A fault is recognised only when the synchronised pin equals the polarity bit (1 = active high, 0 = active low). Pending reads 1 three edges after the pin reaches its active level.
- R4: A recognised fault clears output enable in the same edge that sets pending. From then on every bit of `pwm_drv_en` is 0 and every bit of `pwm_out` is 0.
- R5: `irq_req` is active high and always equals the pending flag.
- R6: A write to address 1 with data bit 3 equal to 0 clears pending on that edge only if the synchronised pin is not at its active level. Otherwise the write is ignored and pending stays 1.
- R7: A write to address 1 with data bit 3 equal to 1 has no effect on pending.
- R8: Writing output enable to 1 is ignored while pending is 1. Otherwise it takes effect on the write edge, after which `pwm_drv_en` is all ones and `pwm_out` follows `pwm_in`.
- R9: While pending is 1, further fault activity on the pin keeps `irq_req` at 1 without a falling or rising edge. Only after a clear can a new fault produce a new rising edge.
- R10: Address 0 holds enable in data bit 0, polarity in data bit 1 and output enable in data bit 2. Writes to any other address leave all of these bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pin | input | 1 | External fault input, asynchronous |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | ADDR_W (2) | Write address: 0 control, 1 status |
| wr_data | input | DATA_W (4) | Write data |
| rd_vec | output | 4 | {enable, polarity, output enable, pending} |
| pwm_in | input | NUM_CH (6) | Drive levels from the PWM generator |
| pwm_out | output | NUM_CH (6) | Drive levels to the pads, 0 when released |
| pwm_drv_en | output | NUM_CH (6) | Per-pad drive enable, 0 means high impedance |
| nmi_cpu | output | 1 | Non-maskable interrupt to the CPU |
| irq_req | output | 1 | Active-high request to the top-level interrupt controller |

## Verification
A register write is due on the edge that samples the strobe, so the bench reads `rd_vec` one time unit after that edge. A pin change reaches `nmi_cpu` after two edges and the pending flag after three, and the bench counts edges from the moment it changes the pin before it samples. The drive-side outputs `pwm_out` and `pwm_drv_en` are combinational from output enable, so the bench checks them in the same sampling slot as the register they depend on. All sampling is done one time unit after a rising edge, never on it.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

    // Control-flow states of the fault capture machine
    typedef enum logic [1:0] {
        ST_BYPASS  = 2'd0,  // disabled, pin routed to the CPU
        ST_ARMED   = 2'd1,  // enabled, watching for the active level
        ST_TRIPPED = 2'd2,  // pending, fault still present
        ST_HELD    = 2'd3   // pending, fault gone, clear permitted
    } fg_state_e;

    // Register addresses
    localparam int unsigned REG_CTRL = 0;
    localparam int unsigned REG_STAT = 1;

    // Bit positions inside the write data
    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_POL_BIT  = 1;
    localparam int unsigned CTRL_OE_BIT   = 2;
    localparam int unsigned STAT_PEND_BIT = 3;

    // Width of the read vector {en, pol, oe, pend}
    localparam int unsigned RD_W = 4;

endpackage

// File: rtl/fault_guard_sync.sv
module fault_guard_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= d;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d};
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fault_guard_fsm.sv
module fault_guard_fsm
    import fault_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,         // enable bit from the control register
    input  logic fault_act,  // synchronised pin at its active level
    input  logic clr_req,    // software asks to clear pending
    output logic pending,
    output logic trip,       // fault recognised this cycle
    output logic clr_ok      // clear accepted this cycle
);

    fg_state_e state_q;
    fg_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BYPASS: begin
                if (en) begin
                    state_d = ST_ARMED;                    // ENABLE
                end
            end
            ST_ARMED: begin
                if (en && fault_act) begin
                    state_d = ST_TRIPPED;                  // TRIP
                end else if (!en) begin
                    state_d = ST_BYPASS;                   // DISARM
                end
            end
            ST_TRIPPED: begin
                if (clr_req && !fault_act) begin
                    state_d = en ? ST_ARMED : ST_BYPASS;   // ACK
                end else if (!fault_act) begin
                    state_d = ST_HELD;                     // RELEASE
                end
            end
            ST_HELD: begin
                if (fault_act) begin
                    state_d = ST_TRIPPED;                  // RETRIP
                end else if (clr_req) begin
                    state_d = en ? ST_ARMED : ST_BYPASS;   // ACK
                end
            end
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        pending = 1'b0;
        trip    = 1'b0;
        clr_ok  = 1'b0;
        unique case (state_q)
            ST_BYPASS: begin
                pending = 1'b0;
            end
            ST_ARMED: begin
                trip = en && fault_act;
            end
            ST_TRIPPED, ST_HELD: begin
                pending = 1'b1;
                clr_ok  = clr_req && !fault_act;
            end
        endcase
    end

endmodule

// File: rtl/fault_guard_regs.sv
module fault_guard_regs
    import fault_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trip,
    input  logic              pending,
    output logic              en,
    output logic              pol,
    output logic              oe,
    output logic              clr_req,
    output logic [RD_W-1:0]   rd_vec
);

    logic ctrl_wr;
    logic stat_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
    assign stat_wr = wr_en && (wr_addr == ADDR_W'(REG_STAT));

    // Only a written zero asks for a clear; a written one is discarded
    assign clr_req = stat_wr && !wr_data[STAT_PEND_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en  <= 1'b0;
            pol <= 1'b1;
        end else if (ctrl_wr) begin
            en  <= wr_data[CTRL_EN_BIT];
            pol <= wr_data[CTRL_POL_BIT];
        end
    end

    // A fault wins over any write; enabling is refused while pending
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe <= 1'b0;
        end else if (trip) begin
            oe <= 1'b0;
        end else if (ctrl_wr) begin
            oe <= wr_data[CTRL_OE_BIT] && !pending;
        end
    end

    assign rd_vec = {en, pol, oe, pending};

endmodule

// File: rtl/fault_guard_outs.sv
module fault_guard_outs #(
    parameter int unsigned NUM_CH = 6
) (
    input  logic              en,
    input  logic              pin_sync,
    input  logic              oe,
    input  logic              pending,
    input  logic [NUM_CH-1:0] pwm_in,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] pwm_drv_en,
    output logic              nmi_cpu,
    output logic              irq_req
);

    // The CPU sees the pin only while the unit is disabled
    assign nmi_cpu = en ? 1'b0 : pin_sync;
    assign irq_req = pending;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pad
            assign pwm_drv_en[ch] = oe;
            assign pwm_out[ch]    = oe & pwm_in[ch];
        end
    endgenerate

endmodule

// File: rtl/fault_guard.sv
module fault_guard
    import fault_guard_pkg::*;
#(
    parameter int unsigned NUM_CH      = 6,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned DATA_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [RD_W-1:0]   rd_vec,
    input  logic [NUM_CH-1:0] pwm_in,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] pwm_drv_en,
    output logic              nmi_cpu,
    output logic              irq_req
);

    logic pin_sync;
    logic fault_act;
    logic en_q;
    logic pol_q;
    logic oe_q;
    logic clr_req;
    logic pending;
    logic trip;
    logic clr_ok;

    fault_guard_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (fault_pin),
        .q     (pin_sync)
    );

    assign fault_act = (pin_sync == pol_q);

    fault_guard_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .trip    (trip),
        .pending (pending),
        .en      (en_q),
        .pol     (pol_q),
        .oe      (oe_q),
        .clr_req (clr_req),
        .rd_vec  (rd_vec)
    );

    fault_guard_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .fault_act (fault_act),
        .clr_req   (clr_req),
        .pending   (pending),
        .trip      (trip),
        .clr_ok    (clr_ok)
    );

    fault_guard_outs #(
        .NUM_CH (NUM_CH)
    ) u_outs (
        .en         (en_q),
        .pin_sync   (pin_sync),
        .oe         (oe_q),
        .pending    (pending),
        .pwm_in     (pwm_in),
        .pwm_out    (pwm_out),
        .pwm_drv_en (pwm_drv_en),
        .nmi_cpu    (nmi_cpu),
        .irq_req    (irq_req)
    );

endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk #(
    parameter int unsigned NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              fault_act,
    input logic              clr_ok,
    input logic              irq_req,
    input logic              nmi_cpu,
    input logic              oe,
    input logic [NUM_CH-1:0] pwm_drv_en
);

    // R4: a raised request always comes with every pad released
    assert_pend_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pwm_drv_en == '0));

    // R3: the CPU line stays quiet while the unit owns the pin
    assert_nmi_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !nmi_cpu);

    // R3: a new request edge needs an enabled unit and an active pin
    assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(en && fault_act));

    // R6: the request only falls after an accepted clear with an idle pin
    assert_clear_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_req) |-> $past(clr_ok && !fault_act));

    // R8: the drive cannot be enabled while a fault is pending
    assert_no_oe_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !oe);

endmodule

bind fault_guard fault_guard_chk #(
    .NUM_CH (NUM_CH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_q),
    .fault_act  (fault_act),
    .clr_ok     (clr_ok),
    .irq_req    (irq_req),
    .nmi_cpu    (nmi_cpu),
    .oe         (oe_q),
    .pwm_drv_en (pwm_drv_en)
);

// File: tb/fault_guard_bench.sv
module fault_guard_bench;

    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           fault_pin;
    logic           wr_en;
    logic [1:0]     wr_addr;
    logic [3:0]     wr_data;
    logic [3:0]     rd_vec;
    logic [NCH-1:0] pwm_in;
    logic [NCH-1:0] pwm_out;
    logic [NCH-1:0] pwm_drv_en;
    logic           nmi_cpu;
    logic           irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    fault_guard u_fault_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_pin  (fault_pin),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_vec     (rd_vec),
        .pwm_in     (pwm_in),
        .pwm_out    (pwm_out),
        .pwm_drv_en (pwm_drv_en),
        .nmi_cpu    (nmi_cpu),
        .irq_req    (irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = 2'd0;
        wr_data = 4'd0;
        pwm_in  = '0;
        tick(2);
        rst_n = 1'b1;
        tick(3);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick(1);
        wr_en   = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pat;
        logic        prev;

        fault_pin = 1'b0;
        do_reset();

        // R1: reset state
        check("R1 rd_vec", rd_vec, 4'b0100);
        check("R1 irq", irq_req, 0);
        check("R1 drv", pwm_drv_en, 0);

        // R2: pass-through sweep while disabled
        pat  = 16'hA5C3;
        prev = 1'b0;
        for (int k = 0; k < 16; k++) begin
            fault_pin = pat[k];
            tick(1);
            check("R2 nmi follows pin", nmi_cpu, prev);
            check("R2 no pending", rd_vec[0], 0);
            prev = pat[k];
        end

        // R2: pin active while disabled leaves oe and flags alone
        do_reset();
        wr(2'd0, 4'h6);
        fault_pin = 1'b1;
        tick(4);
        check("R2 oe kept", rd_vec, 4'b0110);
        check("R2 irq low", irq_req, 0);
        check("R2 nmi high", nmi_cpu, 1);

        // R3/R4/R5: polarity x pin level sweep
        for (int pl = 0; pl < 2; pl++) begin
            for (int pv = 0; pv < 2; pv++) begin
                logic act;
                act = (pv == pl);
                fault_pin = pv[0];
                do_reset();
                pwm_in = 6'h2A;
                wr(2'd0, {1'b0, 1'b1, pl[0], 1'b1});
                tick(2);
                check("R3 pending by level", rd_vec[0], act);
                check("R3 nmi quiet", nmi_cpu, 0);
                check("R4 oe cleared", rd_vec[1], !act);
                check("R4 drv", pwm_drv_en, act ? 6'h00 : 6'h3F);
                check("R4 pwm_out", pwm_out, act ? 6'h00 : 6'h2A);
                check("R5 irq = pending", irq_req, act);
            end
        end

        // R8: outputs follow pwm_in while driving
        fault_pin = 1'b0;
        do_reset();
        wr(2'd0, 4'h7);
        for (int v = 0; v < 64; v++) begin
            pwm_in = v[5:0];
            #1;
            check("R8 pwm_out follows", pwm_out, v[5:0]);
        end
        check("R8 drv all ones", pwm_drv_en, 6'h3F);

        // Trip with active-high polarity: pin high, three edges
        fault_pin = 1'b1;
        tick(3);
        check("R3 tripped", rd_vec, 4'b1101);

        // R6: clear refused while pin active
        wr(2'd1, 4'h0);
        check("R6 clear refused", rd_vec[0], 1);
        // R7: writing one has no effect
        wr(2'd1, 4'h8);
        check("R7 write one", rd_vec[0], 1);
        // R8: enabling refused while pending
        wr(2'd0, 4'h7);
        check("R8 oe refused", rd_vec[1], 0);
        check("R8 drv released", pwm_drv_en, 0);

        // R9: request stays high through further fault activity
        for (int k = 0; k < 8; k++) begin
            fault_pin = (k >= 4);
            tick(1);
            check("R9 irq held", irq_req, 1);
        end

        // R6: clear accepted once the pin is idle
        fault_pin = 1'b0;
        tick(3);
        wr(2'd1, 4'h0);
        check("R6 clear accepted", rd_vec[0], 0);
        check("R6 irq low", irq_req, 0);

        // R8: enabling accepted after clear
        wr(2'd0, 4'h7);
        check("R8 oe set", rd_vec, 4'b1110);
        check("R8 drv on", pwm_drv_en, 6'h3F);

        // R7: writing one while idle leaves pending clear
        wr(2'd1, 4'h8);
        check("R7 no set", rd_vec[0], 0);

        // R9: new fault after a clear produces a new request
        fault_pin = 1'b1;
        tick(2);
        check("R9 not yet", irq_req, 0);
        tick(1);
        check("R9 new request", irq_req, 1);

        // R10: register map and unmapped address
        fault_pin = 1'b0;
        do_reset();
        wr(2'd0, 4'h3);
        check("R10 en+pol", rd_vec, 4'b1100);
        wr(2'd2, 4'hF);
        check("R10 unmapped", rd_vec, 4'b1100);
        wr(2'd3, 4'h0);
        check("R10 unmapped zero", rd_vec, 4'b1100);
        wr(2'd0, 4'h0);
        check("R10 all clear", rd_vec, 4'b0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule